// File: doc/BRIEF.md
# Four-Character Command Mailbox

This block is the register-side target of a host command channel. A host reaches it through a plain byte-addressed register bus and submits commands made of four ASCII characters. It offers two mailboxes that work independently. Each mailbox pairs a four-byte command register with a sixteen-byte data register. The host first loads any parameters into the data register. It then writes the four command characters, and the fourth character starts execution.

A small executor inside the block decodes four command codes and produces an output payload from the data register. `ECHO` returns the data unchanged. `INVB` inverts every bit. `REVS` reverses the byte order. `SUMB` places the modulo-256 byte sum in byte 0 and zeroes the other bytes. Every command takes a fixed number of cycles.

When a command finishes, the command register reports the result. It reads back four zero bytes on success and the text `!CMD` on failure. A per-mailbox completion bit is also set in an event register. The host can mask those bits and clear them by writing ones, and they drive a level interrupt.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, the command and data registers read 0x00, the event register (0x14) and mask register (0x16) read 0x00, and `irq` is low.
- R2: The command and data registers are multi-byte registers reached through a byte index. The index advances by one on every access to the same address and returns to 0 whenever the accessed address differs from the previous access. Command bytes wrap modulo 4 and data bytes wrap modulo 16. Addresses that are not mapped read 0x00.
- R3: Mailbox A uses command address 0x08 and data address 0x09. Mailbox B uses 0x10 and 0x11. Writing command byte index 3 starts execution. Writing only bytes 0 to 2 starts nothing. Byte 0 is the first character.
- R4: A successful command overwrites its command register with four 0x00 bytes and leaves the output payload in its data register.
- R5: The codes transform the 16 input bytes d[k] as follows. `ECHO` gives out[k]=d[k]. `INVB` gives out[k]=~d[k]. `REVS` gives out[k]=d[15-k]. `SUMB` gives out[0]=sum of d mod 256 and out[k]=0 for k>0.
- R6: Any other code completes with the command register reading '!','C','M','D' at byte indices 0 to 3, and the data register keeps its input contents.
- R7: While a mailbox is executing, its command register reads back the original characters, and writes to that mailbox's command and data registers are ignored.
- R8: Completion sets event bit 0 for mailbox A and bit 1 for mailbox B in the event register at 0x14.
- R9: Writing the clear register at 0x18 clears each event bit written as 1 and leaves bits written as 0 unchanged.
- R10: `irq` is high exactly when some event bit is set and its bit in the read/write mask register at 0x16 is 1.
- R11: The two mailboxes execute concurrently and independently of each other.
- R12: Results and the event bit become visible 4 clock cycles after the clock edge that writes command byte 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write byte |
| we | input | 1 | Write strobe, one byte per cycle |
| re | input | 1 | Read strobe, one byte per cycle |
| rdata | output | 8 | Read byte, combinational while `re` is high |
| irq | output | 1 | Level interrupt from unmasked events |

## Verification
A wrong byte index shows up on the next read as bytes that have shifted or repeated. A bad busy flag or latency counter shows up as a completion bit in 0x14 that appears a cycle early or late, or as a command register that changes to its result code while the host still expects the original characters. A wrong result decode or transform reaches the ports only when the payload is read back after completion. For that reason, each command's full command and data contents are compared with an independently computed expectation. An event or mask fault shows up on `irq` in the cycle after the offending write.

// File: rtl/cmd_mailbox.sv
module cmd_mailbox #(
  parameter int ADDR_W     = 8,
  parameter int DATA_BYTES = 16,
  parameter int LATENCY    = 4,
  parameter int NUM_MB     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              we,
  input  logic              re,
  output logic [7:0]        rdata,
  output logic              irq
);
  localparam int CMD_BYTES = 4;
  localparam int IDX_W     = $clog2(DATA_BYTES);
  localparam int CNT_W     = $clog2(LATENCY + 1);
  localparam logic [ADDR_W-1:0] EVT_ADDR = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] MSK_ADDR = ADDR_W'(8'h16);
  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(8'h18);

  function automatic logic [ADDR_W-1:0] cmd_addr(input int m);
    return ADDR_W'(8 * (m + 1));
  endfunction

  logic [ADDR_W-1:0] last_addr;
  logic              last_vld;
  logic [IDX_W-1:0]  idx;
  wire               acc  = we | re;
  wire [IDX_W-1:0]   eidx = (last_vld && addr == last_addr) ? idx : '0;

  logic [NUM_MB-1:0][CMD_BYTES-1:0][7:0]  cmdr;
  logic [NUM_MB-1:0][DATA_BYTES-1:0][7:0] datr;
  logic [NUM_MB-1:0][DATA_BYTES-1:0][7:0] res;
  logic [NUM_MB-1:0][31:0]                cmd_code;
  logic [NUM_MB-1:0][CNT_W-1:0]           cnt;
  logic [NUM_MB-1:0] busy, evt, mask, ok, done;

  wire [NUM_MB-1:0] clr = (we && addr == CLR_ADDR) ? wdata[NUM_MB-1:0] : '0;
  assign irq = |(evt & mask);

  always_comb begin
    logic [7:0] s;
    for (int m = 0; m < NUM_MB; m++) begin
      cmd_code[m] = {cmdr[m][0], cmdr[m][1], cmdr[m][2], cmdr[m][3]};
      done[m] = busy[m] && cnt[m] == '0;
      ok[m]   = 1'b1;
      res[m]  = datr[m];
      s       = '0;
      case (cmd_code[m])
        "ECHO": res[m] = datr[m];
        "INVB": res[m] = ~datr[m];
        "REVS": for (int k = 0; k < DATA_BYTES; k++) res[m][k] = datr[m][DATA_BYTES-1-k];
        "SUMB": begin
          for (int k = 0; k < DATA_BYTES; k++) s = s + datr[m][k];
          res[m]    = '0;
          res[m][0] = s;
        end
        default: ok[m] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_addr <= '0;
      last_vld  <= 1'b0;
      idx       <= '0;
      cmdr      <= '0;
      datr      <= '0;
      cnt       <= '0;
      busy      <= '0;
      evt       <= '0;
      mask      <= '0;
    end else begin
      if (acc) begin
        last_addr <= addr;
        last_vld  <= 1'b1;
        idx       <= eidx + IDX_W'(1);
      end
      for (int m = 0; m < NUM_MB; m++) begin
        if (busy[m]) begin
          if (done[m]) begin
            busy[m] <= 1'b0;
            cmdr[m] <= ok[m] ? '0 : 32'h444D4321;
            if (ok[m]) datr[m] <= res[m];
          end else begin
            cnt[m] <= cnt[m] - CNT_W'(1);
          end
        end else if (we && addr == cmd_addr(m)) begin
          cmdr[m][eidx[1:0]] <= wdata;
          if (eidx[1:0] == 2'd3) begin
            busy[m] <= 1'b1;
            cnt[m]  <= CNT_W'(LATENCY - 1);
          end
        end else if (we && addr == cmd_addr(m) + ADDR_W'(1)) begin
          datr[m][eidx] <= wdata;
        end
      end
      evt <= (evt & ~clr) | done;
      if (we && addr == MSK_ADDR) mask <= wdata[NUM_MB-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (re) begin
      for (int m = 0; m < NUM_MB; m++) begin
        if (addr == cmd_addr(m)) rdata = cmdr[m][eidx[1:0]];
        if (addr == cmd_addr(m) + ADDR_W'(1)) rdata = datr[m][eidx];
      end
      if (addr == EVT_ADDR) rdata[NUM_MB-1:0] = evt;
      if (addr == MSK_ADDR) rdata[NUM_MB-1:0] = mask;
    end
  end
endmodule

// File: rtl/cmd_mailbox_chk.sv
module cmd_mailbox_chk #(
  parameter int NUM_MB  = 2,
  parameter int LATENCY = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_MB-1:0]       busy,
  input logic [NUM_MB-1:0]       evt,
  input logic [NUM_MB-1:0]       mask,
  input logic                    irq,
  input logic [NUM_MB-1:0][31:0] cmdw
);
  for (genvar m = 0; m < NUM_MB; m++) begin : g_mb
    logic [15:0] bcnt;
    always_ff @(posedge clk) begin
      if (!rst_n)       bcnt <= '0;
      else if (busy[m]) bcnt <= bcnt + 16'd1;
      else              bcnt <= '0;
    end

    AST_DONE_SETS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[m]) |-> evt[m]); // R8
    AST_RESULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[m]) |-> (cmdw[m] == 32'h0 || cmdw[m] == "!CMD")); // R6
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[m] && $past(busy[m])) |-> $stable(cmdw[m])); // R7
    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[m]) |-> bcnt == 16'(LATENCY)); // R12
  end

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R10
endmodule

bind cmd_mailbox cmd_mailbox_chk #(.NUM_MB(NUM_MB), .LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .evt(evt), .mask(mask),
  .irq(irq), .cmdw(cmd_code)
);

// File: tb/cmd_mailbox_tb.sv
`timescale 1ns/1ps
module cmd_mailbox_tb;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, re = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic irq;
  int checks = 0, failures = 0;

  typedef struct packed {
    logic [7:0]        mb;
    logic [31:0]       code;
    logic [15:0][7:0]  data;
  } exp_t;
  exp_t sb[$];

  cmd_mailbox u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
                     .we(we), .re(re), .rdata(rdata), .irq(irq));

  always #2.5 clk = ~clk;

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1; #1 d = rdata;
    @(posedge clk); #1 re = 1'b0;
  endtask

  task automatic touch();
    logic [7:0] x;
    bus_rd(8'h00, x);
  endtask

  function automatic logic [15:0][7:0] model(input logic [31:0] code,
                                             input logic [15:0][7:0] d,
                                             output logic [31:0] rc);
    logic [15:0][7:0] o;
    logic [7:0] s;
    rc = 32'h0; o = d; s = '0;
    case (code)
      "ECHO": o = d;
      "INVB": for (int k = 0; k < 16; k++) o[k] = ~d[k];
      "REVS": for (int k = 0; k < 16; k++) o[k] = d[15-k];
      "SUMB": begin
        for (int k = 0; k < 16; k++) s = s + d[k];
        o = '0; o[0] = s;
      end
      default: rc = "!CMD";
    endcase
    return o;
  endfunction

  // driver: loads data, writes the command and pushes the expected result
  task automatic start_cmd(input int m, input logic [31:0] code, input logic [15:0][7:0] d);
    exp_t e;
    logic [31:0] rc;
    logic [7:0] base;
    base = 8'(8 * (m + 1));
    touch();
    for (int k = 0; k < 16; k++) bus_wr(base + 8'd1, d[k]);
    for (int k = 0; k < 4; k++) bus_wr(base, code[31-8*k -: 8]);
    e.mb = 8'(m);
    e.data = model(code, d, rc);
    e.code = rc;
    sb.push_back(e);
  endtask

  // monitor: pops the oldest expectation and compares the mailbox contents
  task automatic monitor_pop(input string req);
    exp_t e;
    logic [7:0] base, b, ev;
    e = sb.pop_front();
    base = 8'(8 * (e.mb + 1));
    touch();
    for (int k = 0; k < 4; k++) begin
      bus_rd(base, b);
      chk({req, " cmd byte"}, 32'(b), 32'(e.code[31-8*k -: 8]));
    end
    for (int k = 0; k < 16; k++) begin
      bus_rd(base + 8'd1, b);
      chk({req, " data byte"}, 32'(b), 32'(e.data[k]));
    end
    bus_rd(8'h14, ev);
    chk("R8 event bit", 32'(ev[e.mb[0]]), 32'd1);
  endtask

  task automatic clear_all();
    bus_wr(8'h18, 8'h03);
  endtask

  logic [15:0][7:0] pa, pb, pc;
  logic [7:0] v;

  initial begin
    for (int k = 0; k < 16; k++) begin
      pa[k] = 8'(k * 17 + 3);
      pb[k] = 8'(8'hF0 - k * 5);
      pc[k] = 8'(k);
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    touch();
    for (int k = 0; k < 4; k++) begin bus_rd(8'h08, v); chk("R1 cmd A", 32'(v), 0); end
    bus_rd(8'h11, v); chk("R1 data B", 32'(v), 0);
    bus_rd(8'h14, v); chk("R1 event", 32'(v), 0);
    bus_rd(8'h16, v); chk("R1 mask", 32'(v), 0);
    chk("R1 irq", 32'(irq), 0);

    // R12 exact latency, R4 success on ECHO
    start_cmd(0, "ECHO", pa);
    for (int c = 0; c < 4; c++) begin bus_rd(8'h14, v); chk("R12 not yet done", 32'(v[0]), 0); end
    bus_rd(8'h14, v); chk("R12 done after 4 cycles", 32'(v[0]), 1);
    monitor_pop("R4 ECHO");
    clear_all();

    // R2 index: partial burst, address change resets index
    touch();
    bus_rd(8'h09, v); chk("R2 idx0", 32'(v), 32'(pa[0]));
    bus_rd(8'h09, v); chk("R2 idx1", 32'(v), 32'(pa[1]));
    bus_rd(8'h14, v);
    bus_rd(8'h09, v); chk("R2 idx reset", 32'(v), 32'(pa[0]));
    bus_rd(8'h30, v); chk("R2 unmapped", 32'(v), 0);

    // R3 three command bytes do not start execution
    touch();
    bus_wr(8'h08, "E"); bus_wr(8'h08, "C"); bus_wr(8'h08, "H");
    repeat (6) @(posedge clk);
    bus_rd(8'h14, v); chk("R3 no start on 3 bytes", 32'(v), 0);
    bus_rd(8'h08, v); chk("R3 partial cmd kept", 32'(v), 32'("E"));

    // R7 busy: command reads original, writes ignored
    start_cmd(1, "ECHO", pb);
    touch();
    bus_rd(8'h10, v); chk("R7 cmd held while busy", 32'(v), 32'("E"));
    bus_wr(8'h11, 8'hAA);
    repeat (4) @(posedge clk);
    monitor_pop("R7 write ignored");
    clear_all();

    // R5 transforms
    start_cmd(0, "INVB", pb); repeat (5) @(posedge clk); monitor_pop("R5 INVB"); clear_all();
    start_cmd(1, "REVS", pa); repeat (5) @(posedge clk); monitor_pop("R5 REVS"); clear_all();
    start_cmd(0, "SUMB", pc); repeat (5) @(posedge clk); monitor_pop("R5 SUMB"); clear_all();

    // R6 unknown code
    start_cmd(1, "ZZZZ", pc); repeat (5) @(posedge clk); monitor_pop("R6 unknown"); clear_all();

    // R11 concurrent mailboxes
    start_cmd(0, "REVS", pb);
    start_cmd(1, "INVB", pc);
    repeat (5) @(posedge clk);
    monitor_pop("R11 mailbox A");
    monitor_pop("R11 mailbox B");
    bus_rd(8'h14, v); chk("R11 both events", 32'(v), 3);

    // R10 masking, R9 write-one-to-clear
    chk("R10 masked irq low", 32'(irq), 0);
    bus_wr(8'h16, 8'h01); #1 chk("R10 unmasked irq high", 32'(irq), 1);
    bus_rd(8'h16, v); chk("R10 mask readback", 32'(v), 1);
    bus_wr(8'h18, 8'h02);
    bus_rd(8'h14, v); chk("R9 zero bit kept", 32'(v), 1);
    chk("R10 irq still high", 32'(irq), 1);
    bus_wr(8'h16, 8'h02); #1 chk("R10 other bit masked", 32'(irq), 0);
    bus_wr(8'h18, 8'h01);
    bus_rd(8'h14, v); chk("R9 cleared", 32'(v), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule